// File: doc/BRIEF.md
# FP8 pair dot-product accumulator

This block is one 16-bit lane of a vector unit. Each of its two operand words packs two 8-bit floating-point values. The lane multiplies the low byte of one operand by the low byte of the other, and the high byte by the high byte. It adds the two products, scales that sum down by a power of two, and adds the result into a half-precision (FP16) accumulator word. The whole chain of products, scaling and accumulation is exact, and the FP16 result is rounded only once, at the end.

Each source word has its own format select. Either source can hold the narrow-range format with 4 exponent bits or the wide-range format with 5 exponent bits, so mixed-format operations are allowed. The caller supplies a 4-bit down-scale exponent and a 2-bit rounding mode. The caller writes the result back to the accumulator. An optional output register gives the lane one cycle of latency.

Top module: `fp8_pair_dot_acc`

## Requirements
- R1: With no special values present, `result` equals the FP16 rounding of acc + 2^-S·(A[7:0]·B[7:0] + A[15:8]·B[15:8]). Bytes pair by position, and the lane rounds exactly once. If both products are zero and the accumulator is finite and non-zero, the accumulator passes through unchanged.
- R2: S is the unsigned `scale` input (0 to 15). Every step of S halves the product contribution exactly, with no intermediate loss.
- R3: A format select of 0 decodes bytes as sign / 4 exponent bits / 3 fraction bits with bias 7. This format has no infinities, and exponent 1111 with fraction 111 is NaN. A select of 1 decodes sign / 5 exponent bits / 2 fraction bits with bias 15. In that format, exponent 11111 with fraction 00 is infinity and any other fraction is NaN. Subnormal bytes are exact in both formats. `fmt_a` selects the format for `op_a` and `fmt_b` for `op_b`.
- R4: `rmode` 0 rounds to nearest with ties to even, 1 rounds toward +inf, 2 toward -inf and 3 toward zero. Tiny results round correctly into FP16 subnormals or to a signed zero.
- R5: A rounded magnitude beyond 65504 gives infinity in the nearest mode. It gives 0x7BFF/0xFBFF in the toward-zero mode. In the toward +inf mode it gives +inf for positive results and 0xFBFF for negative ones; the toward -inf mode mirrors this. Finite inputs never produce infinity in the toward-zero mode.
- R6: The result is the quiet NaN 0x7E00 if any byte or the accumulator is NaN, if infinity is multiplied by zero, or if infinities of opposite sign meet. Finite inputs never produce NaN.
- R7: Otherwise, if any product or the accumulator is infinite, the result is the infinity of that sign.
- R8: An exact zero sum is -0 if all three terms are zeros with negative sign, and +0 if all three are zeros with positive sign. In every other case it is -0 in the toward -inf mode and +0 in all other modes.
- R9: With OUT_REG=1, `result` shows the function of the inputs sampled at the previous rising edge. A synchronous active-low reset clears `result` to 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Synchronous active-low reset |
| op_a | input | 16 | First source word, two 8-bit floats |
| op_b | input | 16 | Second source word, two 8-bit floats |
| acc_in | input | 16 | FP16 accumulator value |
| fmt_a | input | 1 | Byte format for op_a (0 narrow-range, 1 wide-range) |
| fmt_b | input | 1 | Byte format for op_b |
| scale | input | 4 | Down-scale exponent S |
| rmode | input | 2 | Rounding mode |
| result | output | 16 | FP16 updated accumulator |

## Verification
The assertions check several properties on every cycle against the inputs of the previous cycle. A NaN input gives the default NaN. Finite inputs give no NaN, and in the toward-zero mode no infinity. Zero products leave a non-zero finite accumulator unchanged. A positive infinite accumulator without competing specials yields +inf. Reset clears the output. Exact rounding of fused sums, tie-breaking, subnormal outputs, overflow saturation and zero signs all depend on exact values. Only the bench can show them, by sweeping every byte of one pair across all format and rounding combinations against an independent arbitrary-precision model.

// File: rtl/fp8dot_pkg.sv
// Package: shared constants and types of the FP8 pair dot-product lane.
// Assumes a fixed-point frame whose bit 0 weighs 2^-LSB_POS; every
// representable product and accumulator value lands exactly in that frame.
package fp8dot_pkg;
    localparam int N_PAIRS    = 2;
    localparam int F8_W       = 8;
    localparam int F16_W      = 16;
    localparam int FRAC16_W   = 10;
    localparam int EXP16_W    = 5;
    localparam int SCL_W      = 4;
    localparam int MANT8_W    = 4;
    localparam int EOFF8_W    = 5;
    localparam int F8_EXP_MIN = -16;            // smallest byte exponent (wide format subnormal)
    localparam int EOFF_MAX   = 29;             // largest byte exponent minus F8_EXP_MIN
    localparam int SCL_MAX    = (1 << SCL_W) - 1;
    localparam int LSB_POS    = -2 * F8_EXP_MIN + SCL_MAX;      // 47
    localparam int PROD_BIAS  = LSB_POS + 2 * F8_EXP_MIN;       // 15
    localparam int PSH_W      = 7;
    localparam int MAG_W      = 2 * EOFF_MAX + PROD_BIAS + 2 * MANT8_W + 1;
    localparam int SUM_W      = MAG_W + $clog2(N_PAIRS + 1) + 1;
    localparam int POS_W      = $clog2(SUM_W);
    localparam int SUB_LSB    = LSB_POS - 24;   // frame bit of FP16 subnormal LSB
    localparam int NORM_MIN_P = SUB_LSB + FRAC16_W;
    localparam int ENC_W      = 17;

    localparam logic [F16_W-1:0] QNAN16 = 16'h7E00;
    localparam logic [F16_W-1:0] INF16  = 16'h7C00;
    localparam logic [F16_W-1:0] MAXF16 = 16'h7BFF;

    typedef enum logic [1:0] {
        RM_RNE = 2'd0,
        RM_UP  = 2'd1,
        RM_DN  = 2'd2,
        RM_RZ  = 2'd3
    } rmode_e;

    typedef struct packed {
        logic                 nan;
        logic                 inf;
        logic                 zero;
        logic                 sgn;
        logic [MANT8_W-1:0]   mant;
        logic [EOFF8_W-1:0]   eoff;
    } f8_unp_t;

    typedef struct packed {
        logic                 nan;
        logic                 inf;
        logic                 zero;
        logic                 sgn;
        logic [MAG_W-1:0]     mag;
    } term_t;
endpackage

// File: rtl/f8_unpack.sv
// Module: f8_unpack
// Splits one 8-bit float into class flags, sign, integer mantissa and a
// non-negative exponent offset (exponent - F8_EXP_MIN), so that
// value = mant * 2^(eoff + F8_EXP_MIN). Assumes fmt_sel 0 = 4/3 layout
// bias 7, fmt_sel 1 = 5/2 layout bias 15. Purely combinational.
module f8_unpack
    import fp8dot_pkg::*;
(
    input  logic [F8_W-1:0] code,
    input  logic            fmt_sel,
    output f8_unp_t         unp
);
    localparam logic [EOFF8_W-1:0] NAR_SUB_EOFF = EOFF8_W'(-9 - F8_EXP_MIN);
    localparam logic [EOFF8_W-1:0] NAR_ADJ      = EOFF8_W'(-10 - F8_EXP_MIN);
    localparam logic [EOFF8_W-1:0] WID_ADJ      = EOFF8_W'(-(-17 - F8_EXP_MIN));

    logic [3:0] e_nar;
    logic [2:0] f_nar;
    logic [4:0] e_wid;
    logic [1:0] f_wid;

    assign e_nar = code[6:3];
    assign f_nar = code[2:0];
    assign e_wid = code[6:2];
    assign f_wid = code[1:0];

    // Decode the byte according to the selected layout.
    always_comb begin
        unp     = '0;
        unp.sgn = code[F8_W-1];
        if (!fmt_sel) begin
            if (e_nar == 4'hF && f_nar == 3'h7) begin
                unp.nan = 1'b1;
            end else if (e_nar == 4'h0) begin
                unp.mant = {1'b0, f_nar};
                unp.eoff = NAR_SUB_EOFF;
            end else begin
                unp.mant = {1'b1, f_nar};
                unp.eoff = EOFF8_W'(e_nar) + NAR_ADJ;
            end
        end else begin
            if (e_wid == 5'h1F) begin
                unp.nan = (f_wid != 2'b00);
                unp.inf = (f_wid == 2'b00);
            end else if (e_wid == 5'h00) begin
                unp.mant = {2'b00, f_wid};
                unp.eoff = '0;
            end else begin
                unp.mant = {2'b01, f_wid};
                unp.eoff = e_wid - WID_ADJ;
            end
        end
        unp.zero = !unp.nan && !unp.inf && (unp.mant == '0);
    end
endmodule

// File: rtl/f8_product.sv
// Module: f8_product
// Multiplies two unpacked bytes exactly and places the product, already
// divided by 2^scale, into the common fixed-point frame. Flags inf*0 and
// NaN operands as an invalid (NaN) term. Purely combinational.
module f8_product
    import fp8dot_pkg::*;
(
    input  f8_unp_t          a,
    input  f8_unp_t          b,
    input  logic [SCL_W-1:0] scale,
    output term_t            term
);
    logic [2*MANT8_W-1:0] prod;
    logic [PSH_W-1:0]     shamt;

    // Exact integer product and its frame position.
    always_comb begin
        prod  = a.mant * b.mant;
        shamt = PSH_W'(a.eoff) + PSH_W'(b.eoff) + PSH_W'(PROD_BIAS) - PSH_W'(scale);
    end

    // Classify the product and align its magnitude.
    always_comb begin
        term.sgn  = a.sgn ^ b.sgn;
        term.nan  = a.nan | b.nan | (a.inf & b.zero) | (b.inf & a.zero);
        term.inf  = (a.inf | b.inf) & ~term.nan;
        term.zero = (a.zero | b.zero) & ~term.nan & ~term.inf;
        if (term.nan || term.inf) term.mag = '0;
        else                      term.mag = MAG_W'(prod) << shamt;
    end
endmodule

// File: rtl/f8dot_combine.sv
// Module: f8dot_combine
// Decodes the FP16 accumulator, sums it with all product terms exactly in
// two's complement, and resolves NaN, infinity and exact-zero outcomes.
// When special_hit is low, sum_sgn/sum_mag carry the non-zero exact sum.
module f8dot_combine
    import fp8dot_pkg::*;
(
    input  term_t              terms [N_PAIRS],
    input  logic [F16_W-1:0]   acc_word,
    input  rmode_e             rm,
    output logic               special_hit,
    output logic [F16_W-1:0]   special_word,
    output logic               sum_sgn,
    output logic [SUM_W-1:0]   sum_mag
);
    logic [EXP16_W-1:0]  acc_e;
    logic [FRAC16_W-1:0] acc_f;
    logic                acc_nan, acc_inf, acc_zero, acc_sgn;
    logic [FRAC16_W:0]   acc_mant;
    logic [POS_W-1:0]    acc_sh;
    logic [SUM_W-1:0]    acc_mag;
    logic [SUM_W-1:0]    total;
    logic                any_nan, pos_inf, neg_inf;
    logic                all_zero, all_neg, all_pos, zero_sgn;

    assign acc_e   = acc_word[F16_W-2 -: EXP16_W];
    assign acc_f   = acc_word[FRAC16_W-1:0];
    assign acc_sgn = acc_word[F16_W-1];

    // Classify and align the accumulator into the frame.
    always_comb begin
        acc_nan  = (acc_e == '1) && (acc_f != '0);
        acc_inf  = (acc_e == '1) && (acc_f == '0);
        acc_zero = (acc_e == '0) && (acc_f == '0);
        acc_mant = {(acc_e != '0), acc_f};
        acc_sh   = (acc_e == '0) ? POS_W'(SUB_LSB) : POS_W'(acc_e) + POS_W'(SUB_LSB - 1);
        acc_mag  = (acc_e == '1) ? '0 : SUM_W'(acc_mant) << acc_sh;
    end

    // Exact signed sum of all terms and collection of class flags.
    always_comb begin
        total    = acc_sgn ? -acc_mag : acc_mag;
        any_nan  = acc_nan;
        pos_inf  = acc_inf & ~acc_sgn;
        neg_inf  = acc_inf & acc_sgn;
        all_zero = acc_zero;
        all_neg  = acc_sgn;
        all_pos  = ~acc_sgn;
        for (int k = 0; k < N_PAIRS; k++) begin
            total    = total + (terms[k].sgn ? -SUM_W'(terms[k].mag) : SUM_W'(terms[k].mag));
            any_nan  = any_nan | terms[k].nan;
            pos_inf  = pos_inf | (terms[k].inf & ~terms[k].sgn);
            neg_inf  = neg_inf | (terms[k].inf & terms[k].sgn);
            all_zero = all_zero & terms[k].zero;
            all_neg  = all_neg & terms[k].sgn;
            all_pos  = all_pos & ~terms[k].sgn;
        end
    end

    // Sign of an exact zero: unanimous zero signs win, else mode decides.
    always_comb begin
        if (all_zero && all_neg)      zero_sgn = 1'b1;
        else if (all_zero && all_pos) zero_sgn = 1'b0;
        else                          zero_sgn = (rm == RM_DN);
    end

    // Pick a special encoding or hand the finite sum to the rounder.
    always_comb begin
        special_hit  = 1'b1;
        special_word = '0;
        if (any_nan || (pos_inf && neg_inf)) begin
            special_word = QNAN16;
        end else if (pos_inf || neg_inf) begin
            special_word = {neg_inf, INF16[F16_W-2:0]};
        end else if (total == '0) begin
            special_word = {zero_sgn, {(F16_W-1){1'b0}}};
        end else begin
            special_hit = 1'b0;
        end
        sum_sgn = total[SUM_W-1];
        sum_mag = sum_sgn ? -total : total;
    end
endmodule

// File: rtl/f16_round.sv
// Module: f16_round
// Rounds a non-zero exact frame magnitude to FP16 once, under the chosen
// mode, covering subnormals and overflow. Assumes mag != 0.
module f16_round
    import fp8dot_pkg::*;
(
    input  logic [SUM_W-1:0] mag,
    input  logic             sgn,
    input  rmode_e           rm,
    output logic [F16_W-1:0] word
);
    logic [POS_W-1:0]     lead;
    logic [POS_W-1:0]     lsb;
    logic [SUM_W-1:0]     kept, below, low_mask;
    logic [FRAC16_W+1:0]  q;
    logic                 guard, sticky, inc, to_inf;
    logic [ENC_W-1:0]     enc;

    // Position of the leading one.
    always_comb begin
        lead = '0;
        for (int i = 0; i < SUM_W; i++) begin
            if (mag[i]) lead = POS_W'(i);
        end
    end

    // Choose the result LSB (normal or fixed subnormal) and split the bits.
    always_comb begin
        lsb      = (lead >= POS_W'(NORM_MIN_P)) ? lead - POS_W'(FRAC16_W) : POS_W'(SUB_LSB);
        kept     = mag >> lsb;
        below    = mag >> (lsb - POS_W'(1));
        low_mask = (SUM_W'(1) << (lsb - POS_W'(1))) - SUM_W'(1);
        q        = kept[FRAC16_W+1:0];
        guard    = below[0];
        sticky   = |(mag & low_mask);
    end

    // Rounding increment for the selected mode.
    always_comb begin
        unique case (rm)
            RM_RNE:  inc = guard & (sticky | q[0]);
            RM_UP:   inc = ~sgn & (guard | sticky);
            RM_DN:   inc = sgn & (guard | sticky);
            default: inc = 1'b0;
        endcase
    end

    // Encode; a mantissa carry flows into the exponent field naturally.
    always_comb begin
        enc    = ((ENC_W'(lsb) - ENC_W'(SUB_LSB)) << FRAC16_W) + ENC_W'(q) + ENC_W'(inc);
        to_inf = (rm == RM_RNE) | ((rm == RM_UP) & ~sgn) | ((rm == RM_DN) & sgn);
        if (enc >= ENC_W'(INF16)) begin
            word = {sgn, to_inf ? INF16[F16_W-2:0] : MAXF16[F16_W-2:0]};
        end else begin
            word = {sgn, enc[F16_W-2:0]};
        end
    end
endmodule

// File: rtl/fp8_pair_dot_acc.sv
// Module: fp8_pair_dot_acc (top)
// One lane: result = round(acc_in + 2^-scale * sum of byte-pair products),
// rounded once. Byte k of op_a pairs with byte k of op_b. With OUT_REG=1
// the result is registered (one cycle, synchronous active-low reset).
module fp8_pair_dot_acc
    import fp8dot_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [F16_W-1:0]     op_a,
    input  logic [F16_W-1:0]     op_b,
    input  logic [F16_W-1:0]     acc_in,
    input  logic                 fmt_a,
    input  logic                 fmt_b,
    input  logic [SCL_W-1:0]     scale,
    input  logic [1:0]           rmode,
    output logic [F16_W-1:0]     result
);
    f8_unp_t           ua [N_PAIRS];
    f8_unp_t           ub [N_PAIRS];
    term_t             terms [N_PAIRS];
    logic              spec_hit, s_sgn;
    logic [F16_W-1:0]  spec_word, rnd_word, next_res;
    logic [SUM_W-1:0]  s_mag;
    rmode_e            rm;

    assign rm = rmode_e'(rmode);

    for (genvar k = 0; k < N_PAIRS; k++) begin : g_pair
        f8_unpack u_unp_a (.code(op_a[k*F8_W +: F8_W]), .fmt_sel(fmt_a), .unp(ua[k]));
        f8_unpack u_unp_b (.code(op_b[k*F8_W +: F8_W]), .fmt_sel(fmt_b), .unp(ub[k]));
        f8_product u_prod (.a(ua[k]), .b(ub[k]), .scale(scale), .term(terms[k]));
    end

    f8dot_combine u_comb (
        .terms(terms), .acc_word(acc_in), .rm(rm),
        .special_hit(spec_hit), .special_word(spec_word),
        .sum_sgn(s_sgn), .sum_mag(s_mag)
    );

    f16_round u_rnd (.mag(s_mag), .sgn(s_sgn), .rm(rm), .word(rnd_word));

    // Final selection between special outcomes and the rounded sum.
    always_comb next_res = spec_hit ? spec_word : rnd_word;

    if (OUT_REG) begin : g_reg
        logic [F16_W-1:0] res_q;
        logic             in_nan, in_inf, prods_zero, acc_fin_nz;

        // Output register.
        always_ff @(posedge clk) begin
            if (!rst_n) res_q <= '0;
            else        res_q <= next_res;
        end
        assign result = res_q;

        // Input class summary used only by the assertions below.
        always_comb begin
            in_nan     = (acc_in[14:10] == 5'h1F) && (acc_in[9:0] != '0);
            in_inf     = (acc_in[14:10] == 5'h1F) && (acc_in[9:0] == '0);
            acc_fin_nz = (acc_in[14:10] != 5'h1F) && (acc_in[14:0] != '0);
            prods_zero = 1'b1;
            for (int k = 0; k < N_PAIRS; k++) begin
                in_nan     = in_nan | ua[k].nan | ub[k].nan;
                in_inf     = in_inf | ua[k].inf | ub[k].inf;
                prods_zero = prods_zero & terms[k].zero;
            end
        end

        assert_reset_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(rst_n) |-> result == '0);
        assert_nan_input_default_R6: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(in_nan)) |-> result == QNAN16);
        assert_finite_never_nan_R6: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(!in_nan && !in_inf)) |->
            !(result[14:10] == 5'h1F && result[9:0] != '0));
        assert_rz_never_inf_R5: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(!in_nan && !in_inf && rmode == 2'd3)) |->
            result[14:0] != INF16[14:0]);
        assert_zero_products_keep_acc_R1: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(prods_zero && acc_fin_nz)) |-> result == $past(acc_in));
        assert_pos_inf_acc_R7: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(acc_in == INF16 && !in_nan && prods_zero)) |->
            result == INF16);
    end else begin : g_comb
        assign result = next_res;
    end
endmodule

// File: tb/fp8_pair_dot_acc_tb_top.sv
`timescale 1ns/1ps
module fp8_pair_dot_acc_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] op_a, op_b, acc_in;
    logic        fmt_a, fmt_b;
    logic [3:0]  scale;
    logic [1:0]  rmode;
    logic [15:0] result;
    int          total = 0;
    int          bad = 0;
    bit          done = 1'b0;
    logic [31:0] lf = 32'h1234_5679;

    always #10 clk = ~clk;

    fp8_pair_dot_acc #(.OUT_REG(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .acc_in(acc_in),
        .fmt_a(fmt_a), .fmt_b(fmt_b), .scale(scale), .rmode(rmode), .result(result)
    );

    // Byte model: value = mant * 2^ex.
    function automatic void dec8(input logic [7:0] c, input logic f,
                                 output bit nan, output bit inf, output int mant, output int ex);
        int e, fr;
        nan = 0; inf = 0; mant = 0; ex = 0;
        if (!f) begin
            e = int'(c[6:3]); fr = int'(c[2:0]);
            if (e == 15 && fr == 7) nan = 1;
            else if (e == 0) begin mant = fr; ex = -9; end
            else begin mant = 8 + fr; ex = e - 10; end
        end else begin
            e = int'(c[6:2]); fr = int'(c[1:0]);
            if (e == 31) begin if (fr != 0) nan = 1; else inf = 1; end
            else if (e == 0) begin mant = fr; ex = -16; end
            else begin mant = 4 + fr; ex = e - 17; end
        end
    endfunction

    // Magnitude of a positive FP16 code in units of 2^-47; 0x7C00 maps to 2^16.
    function automatic logic signed [127:0] v16(input logic [14:0] c);
        int e, fr;
        e = int'(c[14:10]); fr = int'(c[9:0]);
        if (e == 31) return 128'sd1 <<< 63;
        if (e == 0) return 128'(fr) <<< 23;
        return 128'(1024 + fr) <<< (e + 22);
    endfunction

    function automatic logic [15:0] ref_res(input logic [15:0] a, b, ac, input logic fa, fb,
                                            input logic [3:0] s, input logic [1:0] rm);
        bit nanf = 0, pinf = 0, ninf = 0, allz = 1, alln = 1, allp = 1;
        bit an, ai, bn, bi, sg;
        int am, ae, bm, be, lo, hi, mid, pick;
        logic signed [127:0] tot = 0, mag, vlo, vhi;
        for (int k = 0; k < 2; k++) begin
            dec8(a[8*k +: 8], fa, an, ai, am, ae);
            dec8(b[8*k +: 8], fb, bn, bi, bm, be);
            sg = a[8*k+7] ^ b[8*k+7];
            if (an || bn) nanf = 1;
            else if (ai || bi) begin
                allz = 0;
                if ((ai && !bi && bm == 0) || (bi && !ai && am == 0)) nanf = 1;
                else if (sg) ninf = 1;
                else pinf = 1;
            end else begin
                mag = 128'(am * bm) <<< (ae + be - int'(s) + 47);
                if (mag != 0) allz = 0;
                tot = sg ? tot - mag : tot + mag;
            end
            if (sg) allp = 0; else alln = 0;
        end
        if (ac[14:10] == 5'h1F) begin
            allz = 0;
            if (ac[9:0] != 0) nanf = 1;
            else if (ac[15]) ninf = 1;
            else pinf = 1;
        end else begin
            mag = v16(ac[14:0]);
            if (mag != 0) allz = 0;
            tot = ac[15] ? tot - mag : tot + mag;
        end
        if (ac[15]) allp = 0; else alln = 0;
        if (nanf || (pinf && ninf)) return 16'h7E00;
        if (pinf) return 16'h7C00;
        if (ninf) return 16'hFC00;
        if (tot == 0) begin
            if (allz && alln) return 16'h8000;
            if (allz && allp) return 16'h0000;
            return (rm == 2'd2) ? 16'h8000 : 16'h0000;
        end
        sg  = (tot < 0);
        mag = sg ? -tot : tot;
        lo = 0; hi = 16'h7BFF;
        while (lo < hi) begin
            mid = (lo + hi + 1) / 2;
            if (v16(15'(mid)) <= mag) lo = mid; else hi = mid - 1;
        end
        vlo = v16(15'(lo));
        vhi = v16(15'(lo + 1));
        if (mag == vlo) pick = lo;
        else if (rm == 2'd0) begin
            if (2 * mag < vlo + vhi) pick = lo;
            else if (2 * mag > vlo + vhi) pick = lo + 1;
            else pick = (lo % 2 == 0) ? lo : lo + 1;
        end else if (rm == 2'd1) pick = sg ? lo : lo + 1;
        else if (rm == 2'd2) pick = sg ? lo + 1 : lo;
        else pick = lo;
        return {sg, 15'(pick)};
    endfunction

    // Apply one vector at a falling edge, check after the next rising edge.
    task automatic chk(input logic [15:0] a, b, ac, input logic fa, fb,
                       input logic [3:0] s, input logic [1:0] rm, input string tag);
        logic [15:0] exp_v;
        op_a = a; op_b = b; acc_in = ac; fmt_a = fa; fmt_b = fb; scale = s; rmode = rm;
        exp_v = ref_res(a, b, ac, fa, fb, s, rm);
        @(posedge clk);
        @(negedge clk);
        total++;
        if (result !== exp_v) begin
            bad++;
            $display("FAIL %s: a=%h b=%h acc=%h fa=%0d fb=%0d s=%0d rm=%0d actual=%h expected=%h",
                     tag, a, b, ac, fa, fb, s, rm, result, exp_v);
        end
    endtask

    task automatic allrm(input logic [15:0] a, b, ac, input logic fa, fb,
                         input logic [3:0] s, input string tag);
        for (int r = 0; r < 4; r++) chk(a, b, ac, fa, fb, s, 2'(r), tag);
    endtask

    initial begin
        rst_n = 1'b0;
        op_a = 16'h3838; op_b = 16'h3838; acc_in = 16'h3C00;
        fmt_a = 0; fmt_b = 0; scale = 0; rmode = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        total++;
        if (result !== 16'h0000) begin
            bad++;
            $display("FAIL R9 reset: actual=%h expected=0000", result);
        end
        rst_n = 1'b1;

        chk(16'h0038, 16'h4038, 16'h0000, 0, 0, 0, 0, "R1 byte pairing");
        allrm(16'h3838, 16'h3838, 16'h3C00, 0, 0, 0, "R1 two products plus acc");
        allrm(16'h5A13, 16'hC7B2, 16'h4D21, 1, 0, 5, "R1 fused mixed");
        chk(16'h0000, 16'h5A5A, 16'hB123, 0, 1, 7, 1, "R1 zero products keep acc");
        for (int s = 0; s < 16; s++) chk(16'h7E7E, 16'h7E7E, 16'h0001, 0, 0, 4'(s), 0, "R2 scale sweep");
        chk(16'h007F, 16'h0038, 16'h0000, 0, 0, 0, 0, "R3 narrow NaN code");
        chk(16'h0078, 16'h0038, 16'h0000, 0, 0, 0, 0, "R3 narrow top exponent finite");
        chk(16'h007C, 16'h003C, 16'h0000, 1, 1, 0, 0, "R3 wide infinity");
        allrm(16'h0101, 16'h0101, 16'h0000, 0, 0, 0, "R3 narrow subnormals");
        chk(16'h3C3C, 16'h3838, 16'h0000, 1, 0, 0, 0, "R3 independent formats");
        allrm(16'h0001, 16'h0001, 16'h0000, 1, 1, 0, "R4 tiny result");
        allrm(16'h0038, 16'h0038, 16'h3C00, 0, 0, 11, "R4 tie at one");
        allrm(16'h0038, 16'h00B8, 16'h3C01, 0, 0, 11, "R4 tie odd");
        allrm(16'h0007, 16'h0038, 16'h8001, 0, 0, 15, "R4 subnormal output");
        allrm(16'h007B, 16'h0038, 16'h7BFF, 1, 0, 0, "R5 positive overflow");
        allrm(16'h00FB, 16'h0038, 16'hFBFF, 1, 0, 0, "R5 negative overflow");
        chk(16'h3838, 16'h3838, 16'h7C01, 0, 0, 0, 0, "R6 NaN accumulator");
        chk(16'h007C, 16'h0000, 16'h0000, 1, 1, 0, 0, "R6 inf times zero");
        chk(16'hFC7C, 16'h3C3C, 16'h0000, 1, 1, 0, 0, "R6 opposite product infinities");
        chk(16'h007C, 16'h003C, 16'hFC00, 1, 1, 0, 2, "R6 product inf vs acc inf");
        chk(16'h00FC, 16'h003C, 16'h3C00, 1, 1, 0, 0, "R7 negative infinity");
        chk(16'h0000, 16'h0000, 16'h7C00, 0, 0, 0, 3, "R7 infinite accumulator");
        allrm(16'h8080, 16'h3838, 16'h8000, 0, 0, 0, "R8 all negative zeros");
        allrm(16'h0080, 16'h0038, 16'h8000, 0, 0, 0, "R8 mixed zeros");
        allrm(16'h0038, 16'h0038, 16'hBC00, 0, 0, 0, "R8 exact cancellation");

        for (int fa = 0; fa < 2; fa++)
            for (int fb = 0; fb < 2; fb++)
                for (int rm = 0; rm < 4; rm++)
                    for (int a0 = 0; a0 < 256; a0++)
                        for (int j = 0; j < 16; j++) begin
                            lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
                            chk({lf[7:0], 8'(a0)}, {lf[15:8], 8'(j * 17)}, lf[31:16],
                                1'(fa), 1'(fb), lf[11:8], 2'(rm), "R1 R4 sweep");
                        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule